// File: doc/BRIEF.md
# Block-Erase Flash Array Model

This block is a synthesizable behavioural stand-in for a small flash-style non-volatile array, built on ordinary on-chip registers. A host issues one command per cycle on a valid-qualified interface: read a word, program a word, or erase a block. The array is divided into equal blocks. An erase puts every bit of one block back to logic one. A program can only clear bits, because the stored word becomes the AND of the old value and the new data.

Reads finish in one clock. Programs and erases take a parameterised number of cycles, and a busy flag stays high for that whole time. While the model is busy it accepts no commands. Any command it turns away gives a one-cycle error pulse. One boot block is write-protected: a program or erase aimed at it fails at once and changes nothing. Storage starts at reset in the erased, all-ones state.

Top module: `flash_array_model`

## Requirements
- R1: After reset `busy`, `err` and `rd_valid` are low and every word reads as all ones (0xFFFF by default).
- R2: A program command (op code 2'b01) stores the bitwise AND of the word's old value and `cmd_wdata`, so no bit that holds 0 can return to 1.
- R3: A program changes only the addressed word. Every other word in the same block keeps its value.
- R4: An accepted program holds `busy` high for exactly PROG_CYC consecutive cycles (8 by default), starting the cycle after the accepting edge. The new value can be read once `busy` is low again.
- R5: An erase command (op code 2'b10) sets every word of the block selected by the top address bits (`cmd_addr[5:4]` by default) to all ones. It holds `busy` high for exactly ERASE_CYC cycles (64 by default) and leaves the other blocks untouched.
- R6: A program or erase whose block index equals BOOT_BLK (block 0, addresses 0 to 15 by default) raises `err` for one cycle after the command edge, leaves `busy` low and changes no storage.
- R7: Any command presented while `busy` is high is ignored. It produces no read result and no storage change, and it raises `err` for one cycle.
- R8: Op code 2'b11 is invalid. It raises `err` for one cycle and has no other effect.
- R9: A read (op code 2'b00) accepted while idle drives the addressed word on `rd_data`, with `rd_valid` high for exactly one cycle after the accepting edge. `rd_valid` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 00 read, 01 program, 10 erase, 11 invalid |
| cmd_addr | input | 6 | Word address; upper bits select the block |
| cmd_wdata | input | 16 | Data for a program command |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| busy | output | 1 | A program or erase is in progress |
| err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The hardest case to reach is a command that arrives during the final busy cycle of a long operation. On that edge the sequencer is still busy and must reject the command, but the same edge commits the pending write. The bench issues commands mid-operation and after the wait loop has seen `busy` fall, and it counts busy cycles exactly. Reads after each operation show both that the committed value arrived and that the rejected command touched nothing.

// File: rtl/flash_pkg.sv
// Shared command encoding for the flash array model.
package flash_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_BAD   = 2'b11
    } flash_op_e;
endpackage

// File: rtl/flash_cmd_dec.sv
// Command decoder: classifies the presented command as accepted read,
// program, erase, or rejected. Assumes busy comes from the sequencer and
// that the block index is the top BLK_W bits of the address.
module flash_cmd_dec
    import flash_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int BLK_W    = 2,
    parameter int BOOT_BLK = 0
) (
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              busy,
    output logic              go_read,
    output logic              go_prog,
    output logic              go_erase,
    output logic              reject
);
    flash_op_e op;
    logic      boot_hit;

    // Decode the command against busy state and boot-block protection.
    always_comb begin
        op       = flash_op_e'(cmd_op);
        boot_hit = (cmd_addr[ADDR_W-1 -: BLK_W] == BLK_W'(BOOT_BLK));
        go_read  = cmd_valid && !busy && (op == OP_READ);
        go_prog  = cmd_valid && !busy && (op == OP_PROG)  && !boot_hit;
        go_erase = cmd_valid && !busy && (op == OP_ERASE) && !boot_hit;
        reject   = cmd_valid && !(go_read || go_prog || go_erase);
    end
endmodule

// File: rtl/flash_seq.sv
// Operation sequencer: holds busy for the program or erase latency,
// latches the pending operation and pulses a commit on its last cycle.
// Assumes start_prog and start_erase are only raised while idle.
module flash_seq #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              commit_prog,
    output logic              commit_erase,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt;
    logic             pend_erase;

    // Load the latency on start, count down while busy, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt        <= '0;
            pend_erase <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (start_prog || start_erase) begin
            busy       <= 1'b1;
            cnt        <= start_erase ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
            pend_erase <= start_erase;
            pend_addr  <= addr;
            pend_data  <= wdata;
        end
    end

    // Commit strobes fire on the last busy cycle.
    always_comb begin
        commit_prog  = busy && (cnt == '0) && !pend_erase;
        commit_erase = busy && (cnt == '0) &&  pend_erase;
    end
endmodule

// File: rtl/flash_store.sv
// Storage array: erased (all ones) on reset, AND-programs one word,
// erases one whole block, and gives registered reads. Assumes
// BLK_WORDS is a power of two so a block index and offset concatenate.
module flash_store #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int BLK_W     = 2,
    parameter int BLK_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_prog,
    input  logic              commit_erase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              go_read,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int OFF_W = ADDR_W - BLK_W;

    logic [DATA_W-1:0] mem [WORDS];
    logic [BLK_W-1:0]  wr_blk;

    assign wr_blk = wr_addr[ADDR_W-1 -: BLK_W];

    // Update the array: erased on reset, AND on program, ones on block erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (commit_prog) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end else if (commit_erase) begin
            for (int j = 0; j < BLK_WORDS; j++) mem[{wr_blk, OFF_W'(j)}] <= '1;
        end
    end

    // Register the read word and its one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= go_read;
            if (go_read) rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/flash_array_model.sv
// Top of the block-erase flash array model. Ties together the command
// decoder, the busy sequencer and the storage array, and registers the
// one-cycle error pulse. Assumes one command per cycle.
module flash_array_model #(
    parameter int DATA_W    = 16,
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 16,
    parameter int BOOT_BLK  = 0,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cmd_valid,
    input  logic [1:0]                              cmd_op,
    input  logic [$clog2(NUM_BLK*BLK_WORDS)-1:0]    cmd_addr,
    input  logic [DATA_W-1:0]                       cmd_wdata,
    output logic [DATA_W-1:0]                       rd_data,
    output logic                                    rd_valid,
    output logic                                    busy,
    output logic                                    err
);
    localparam int ADDR_W = $clog2(NUM_BLK * BLK_WORDS);
    localparam int BLK_W  = $clog2(NUM_BLK);

    logic              go_read, go_prog, go_erase, reject;
    logic              commit_prog, commit_erase;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;

    flash_cmd_dec #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_dec (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .busy(busy),
        .go_read(go_read), .go_prog(go_prog), .go_erase(go_erase), .reject(reject)
    );

    flash_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_prog(go_prog), .start_erase(go_erase),
        .addr(cmd_addr), .wdata(cmd_wdata), .busy(busy),
        .commit_prog(commit_prog), .commit_erase(commit_erase),
        .pend_addr(pend_addr), .pend_data(pend_data)
    );

    flash_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .BLK_W(BLK_W), .BLK_WORDS(BLK_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .commit_prog(commit_prog), .commit_erase(commit_erase),
        .wr_addr(pend_addr), .wr_data(pend_data), .go_read(go_read), .rd_addr(cmd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Register the rejection as a one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= reject;
    end
endmodule

// File: rtl/flash_array_checks.sv
// Port-level checker for flash_array_model, attached by bind below.
// Assumes the default op encoding from flash_pkg.
module flash_array_checks #(
    parameter int ADDR_W    = 6,
    parameter int BLK_W     = 2,
    parameter int BOOT_BLK  = 0,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              rd_valid,
    input logic              busy,
    input logic              err
);
    logic [31:0] bcnt;

    // Count consecutive busy cycles for the latency window check.
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == 32'(PROG_CYC) || bcnt == 32'(ERASE_CYC)));

    p_boot_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op == 2'b01 || cmd_op == 2'b10) &&
         cmd_addr[ADDR_W-1 -: BLK_W] == BLK_W'(BOOT_BLK)) |=> (err && !busy));

    p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (err && !rd_valid));

    p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(cmd_valid));

    p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11) |=> err);

    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'b00) |=> (rd_valid && !err));

    p_read_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && busy));
endmodule

bind flash_array_model flash_array_checks #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
) u_checks (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .rd_valid(rd_valid), .busy(busy), .err(err)
);

// File: tb/sim_flash_array_model.sv
// Directed bench for flash_array_model: one task per scenario.
module sim_flash_array_model;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] rd_data;
    logic        rd_valid, busy, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_array_model u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one command for one cycle; returns at the negedge after it.
    task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic read_word(input logic [5:0] a, output logic [15:0] d);
        issue(2'b00, a, '0);
        check("R9 rd_valid", {31'd0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 err", {31'd0, err}, 0);
        check("R1 rd_valid", {31'd0, rd_valid}, 0);
        read_word(6'd20, d); check("R1 erased word", {16'd0, d}, 32'hFFFF);
        read_word(6'd63, d); check("R1 last word", {16'd0, d}, 32'hFFFF);
        @(negedge clk);
        check("R9 rd_valid one cycle", {31'd0, rd_valid}, 0);
    endtask

    task automatic t_program;
        int n; logic [15:0] d;
        issue(2'b01, 6'd16, 16'hA5F0);
        check("R4 busy rises", {31'd0, busy}, 1);
        wait_idle(n); check("R4 program busy length", n, PROG_CYC);
        read_word(6'd16, d); check("R4 programmed value", {16'd0, d}, 32'hA5F0);
        read_word(6'd17, d); check("R3 neighbour untouched", {16'd0, d}, 32'hFFFF);
        issue(2'b01, 6'd16, 16'h0FFF); wait_idle(n);
        read_word(6'd16, d); check("R2 AND program", {16'd0, d}, 32'h05F0);
    endtask

    task automatic t_erase;
        int n; logic [15:0] d;
        issue(2'b01, 6'd50, 16'h00FF); wait_idle(n);
        issue(2'b10, 6'd21, 16'h0000);
        wait_idle(n); check("R5 erase busy length", n, ERASE_CYC);
        read_word(6'd16, d); check("R5 block erased", {16'd0, d}, 32'hFFFF);
        read_word(6'd50, d); check("R5 other block kept", {16'd0, d}, 32'h00FF);
    endtask

    task automatic t_protect;
        logic [15:0] d;
        issue(2'b01, 6'd3, 16'h0000);
        check("R6 program err", {31'd0, err}, 1);
        check("R6 program no busy", {31'd0, busy}, 0);
        read_word(6'd3, d); check("R6 boot word unchanged", {16'd0, d}, 32'hFFFF);
        issue(2'b10, 6'd0, 16'h0000);
        check("R6 erase err", {31'd0, err}, 1);
        check("R6 erase no busy", {31'd0, busy}, 0);
    endtask

    task automatic t_busy_reject;
        int n; logic [15:0] d;
        issue(2'b01, 6'd40, 16'h1234);
        issue(2'b00, 6'd40, 16'h0000);
        check("R7 read while busy err", {31'd0, err}, 1);
        check("R7 read while busy no data", {31'd0, rd_valid}, 0);
        issue(2'b01, 6'd41, 16'h0000);
        check("R7 program while busy err", {31'd0, err}, 1);
        @(negedge clk);
        check("R7 err one cycle", {31'd0, err}, 0);
        wait_idle(n);
        read_word(6'd41, d); check("R7 ignored program", {16'd0, d}, 32'hFFFF);
        read_word(6'd40, d); check("R7 first program kept", {16'd0, d}, 32'h1234);
    endtask

    task automatic t_bad_op;
        logic [15:0] d;
        issue(2'b11, 6'd45, 16'h0000);
        check("R8 invalid op err", {31'd0, err}, 1);
        check("R8 invalid op no busy", {31'd0, busy}, 0);
        check("R8 invalid op no read", {31'd0, rd_valid}, 0);
        read_word(6'd45, d); check("R8 storage unchanged", {16'd0, d}, 32'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_program;
        t_erase;
        t_protect;
        t_busy_reject;
        t_bad_op;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule